// File: doc/BRIEF.md
# VPW Receive Symbol Classifier

This block sits behind the input synchronizer of a variable-pulse-width serial receiver. It measures how long the receive line stays at each of its two levels, active and passive. The measurement uses a 1 µs timebase tick. When a level ends, the block names the pulse that just finished: a short data bit, a long data bit, a start-of-frame symbol, or an error. Two conditions are flagged while the line is still at one level, without waiting for it to change: an over-long active level (BREAK) and an over-long passive level (end of frame).

The block tracks whether a frame is open. While no frame is open it waits for a start-of-frame pulse and discards every other pulse as noise. While a frame is open it turns short and long pulses into bit values, and the bit value depends on the level of the pulse. A BREAK, an end of frame or a malformed pulse closes the frame, and the block then waits for a new start-of-frame pulse. Each result appears as a one-cycle strobe together with a symbol code and a bit value. A separate BREAK flag stays high while the BREAK condition persists.

Top module: `vpw_symbol_classifier`

## Requirements
- R1: During and after reset, with no tick pulses and the line passive, `sym_valid`, `sym_code`, `sym_bit` and `break_flag` are all 0, and no frame is open.
- R2: The width of a pulse is the number of cycles with `tick_us` high that are sampled while the line holds its level, excluding the sampling cycle in which the level changes. A tick in that change cycle is not counted.
- R3: With no frame open, an active pulse of 163 to 239 ticks produces a start-of-frame symbol (`sym_code` 2, `sym_bit` 0) and opens a frame.
- R4: With no frame open, every passive pulse and every active pulse shorter than 163 ticks produces no strobe, and the block keeps waiting for a start-of-frame pulse.
- R5: Inside a frame, a pulse of 34 to 95 ticks is short (`sym_code` 0) and a pulse of 96 to 162 ticks is long (`sym_code` 1). A passive pulse decodes to bit 0 when short and 1 when long. An active pulse decodes to bit 1 when short and 0 when long.
- R6: When an active level reaches 240 ticks, in the cycle after that tick is sampled the block strobes a BREAK (`sym_code` 3), raises `break_flag` and closes any open frame. `break_flag` stays high until the line is sampled passive again.
- R7: Inside a frame, when a passive level reaches 239 ticks, in the cycle after that tick is sampled the block strobes end-of-frame (`sym_code` 4) and closes the frame.
- R8: Inside a frame, a pulse shorter than 34 ticks, or a passive pulse of 163 to 238 ticks, produces an error strobe (`sym_code` 5) and closes the frame.
- R9: The pulse timer saturates instead of wrapping. An active level that lasts far beyond 240 ticks gives exactly one BREAK. After a passive level of any length, the next start-of-frame pulse is still recognized.
- R10: Inside a frame, an active pulse of 163 to 239 ticks produces a start-of-frame symbol and the frame stays open.
- R11: Every level-ending symbol is strobed for exactly one cycle, in the cycle after the changed line level is first sampled. Outside strobes, `sym_code` and `sym_bit` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_active | input | 1 | Synchronized receive level, 1 = active, 0 = passive |
| tick_us | input | 1 | One-cycle timebase pulse every microsecond |
| sym_valid | output | 1 | One-cycle symbol strobe |
| sym_code | output | 3 | 0 short, 1 long, 2 start-of-frame, 3 BREAK, 4 end-of-frame, 5 error |
| sym_bit | output | 1 | Decoded bit value for short and long symbols |
| break_flag | output | 1 | High from BREAK detection until the line returns passive |

## Verification
The bench drives pulses that sit exactly on each window edge: 33/34, 95/96, 162/163 and 239 ticks. A design with an off-by-one comparison would report the wrong symbol kind or the wrong bit at those edges. It also drives active levels far past 240 ticks and passive gaps longer than the timer range. A timer that wraps would either strobe a second BREAK or lose the next start-of-frame pulse. Noise pulses are sent while no frame is open, and a passive level is ended just short of the end-of-frame limit. A design that leaked a strobe, or that did not close the frame after an error, would then decode later pulses when it should not.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;

  typedef enum logic [2:0] {
    SYM_SHORT = 3'd0,
    SYM_LONG  = 3'd1,
    SYM_SOF   = 3'd2,
    SYM_BREAK = 3'd3,
    SYM_EOF   = 3'd4,
    SYM_ERR   = 3'd5
  } vpw_sym_e;

  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_FRAME = 1'b1
  } vpw_state_e;

endpackage

// File: rtl/vpw_pulse_timer.sv
module vpw_pulse_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_active,
  input  logic             tick_us,
  output logic             level_q,
  output logic             edge_det,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next,
  output logic             cnt_step
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic lvl_en;

  always_comb begin
    edge_det = rx_active ^ level_q;
    lvl_en   = edge_det;
    cnt_step = 1'b0;
    cnt_next = cnt_q;
    if (edge_det) begin
      cnt_next = '0;
    end else if (tick_us && (cnt_q != CNT_MAX)) begin
      cnt_step = 1'b1;
      cnt_next = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (lvl_en) level_q <= rx_active;
      if (edge_det || cnt_step) cnt_q <= cnt_next;
    end
  end

  // R2
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_det |=> (cnt_q == '0));

  // R9
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !edge_det) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/vpw_pulse_decoder.sv
module vpw_pulse_decoder
  import vpw_rx_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SHORT_MIN = 34,
  parameter int LONG_MIN  = 96,
  parameter int SOF_MIN   = 163,
  parameter int BRK_MIN   = 240
) (
  input  logic             ended_active,
  input  logic [CNT_W-1:0] width,
  input  logic             in_frame,
  output logic             dec_valid,
  output vpw_sym_e         dec_code,
  output logic             dec_bit,
  output logic             dec_frame
);

  localparam logic [CNT_W-1:0] T_SHORT = CNT_W'(SHORT_MIN);
  localparam logic [CNT_W-1:0] T_LONG  = CNT_W'(LONG_MIN);
  localparam logic [CNT_W-1:0] T_SOF   = CNT_W'(SOF_MIN);
  localparam logic [CNT_W-1:0] T_BRK   = CNT_W'(BRK_MIN);

  logic is_short, is_long, is_sof;

  always_comb begin
    is_short = (width >= T_SHORT) && (width < T_LONG);
    is_long  = (width >= T_LONG)  && (width < T_SOF);
    is_sof   = (width >= T_SOF)   && (width < T_BRK);

    dec_valid = 1'b0;
    dec_code  = SYM_SHORT;
    dec_bit   = 1'b0;
    dec_frame = 1'b0;
    if (!in_frame) begin
      if (ended_active && is_sof) begin
        dec_valid = 1'b1;
        dec_code  = SYM_SOF;
        dec_frame = 1'b1;
      end
    end else if (is_short) begin
      dec_valid = 1'b1;
      dec_code  = SYM_SHORT;
      dec_bit   = ended_active;
      dec_frame = 1'b1;
    end else if (is_long) begin
      dec_valid = 1'b1;
      dec_code  = SYM_LONG;
      dec_bit   = ~ended_active;
      dec_frame = 1'b1;
    end else if (is_sof && ended_active) begin
      dec_valid = 1'b1;
      dec_code  = SYM_SOF;
      dec_frame = 1'b1;
    end else begin
      dec_valid = 1'b1;
      dec_code  = SYM_ERR;
    end
  end

endmodule

// File: rtl/vpw_symbol_classifier.sv
module vpw_symbol_classifier
  import vpw_rx_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SHORT_MIN = 34,
  parameter int LONG_MIN  = 96,
  parameter int SOF_MIN   = 163,
  parameter int BRK_MIN   = 240,
  parameter int EOF_MIN   = 239
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_active,
  input  logic       tick_us,
  output logic       sym_valid,
  output logic [2:0] sym_code,
  output logic       sym_bit,
  output logic       break_flag
);

  localparam logic [CNT_W-1:0] T_BRK = CNT_W'(BRK_MIN);
  localparam logic [CNT_W-1:0] T_EOF = CNT_W'(EOF_MIN);

  logic             level_q, edge_det, cnt_step;
  logic [CNT_W-1:0] cnt_q, cnt_next;
  logic             dec_valid, dec_bit, dec_frame;
  vpw_sym_e         dec_code;

  vpw_state_e state_q, state_d;
  vpw_sym_e   code_q, code_d;
  logic       valid_q, valid_d, bit_q, bit_d, brk_q, brk_d;

  vpw_pulse_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_active (rx_active),
    .tick_us   (tick_us),
    .level_q   (level_q),
    .edge_det  (edge_det),
    .cnt_q     (cnt_q),
    .cnt_next  (cnt_next),
    .cnt_step  (cnt_step)
  );

  vpw_pulse_decoder #(
    .CNT_W(CNT_W), .SHORT_MIN(SHORT_MIN), .LONG_MIN(LONG_MIN),
    .SOF_MIN(SOF_MIN), .BRK_MIN(BRK_MIN)
  ) u_decoder (
    .ended_active (level_q),
    .width        (cnt_q),
    .in_frame     (state_q == ST_FRAME),
    .dec_valid    (dec_valid),
    .dec_code     (dec_code),
    .dec_bit      (dec_bit),
    .dec_frame    (dec_frame)
  );

  always_comb begin
    valid_d = 1'b0;
    code_d  = SYM_SHORT;
    bit_d   = 1'b0;
    brk_d   = brk_q;
    state_d = state_q;
    if (edge_det) begin
      brk_d   = 1'b0;
      state_d = dec_frame ? ST_FRAME : ST_HUNT;
      if (dec_valid) begin
        valid_d = 1'b1;
        code_d  = dec_code;
        bit_d   = dec_bit;
      end
    end else if (cnt_step) begin
      if (level_q && (cnt_next == T_BRK)) begin
        valid_d = 1'b1;
        code_d  = SYM_BREAK;
        brk_d   = 1'b1;
        state_d = ST_HUNT;
      end else if (!level_q && (cnt_next == T_EOF) && (state_q == ST_FRAME)) begin
        valid_d = 1'b1;
        code_d  = SYM_EOF;
        state_d = ST_HUNT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      valid_q <= 1'b0;
      code_q  <= SYM_SHORT;
      bit_q   <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
      code_q  <= code_d;
      bit_q   <= bit_d;
      brk_q   <= brk_d;
    end
  end

  assign sym_valid  = valid_q;
  assign sym_code   = code_q;
  assign sym_bit    = bit_q;
  assign break_flag = brk_q;

  // R6
  brk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(break_flag) |-> (sym_valid && code_q == SYM_BREAK));

  // R6
  brk_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    break_flag |-> level_q);

  // R3
  sof_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && code_q == SYM_SOF) |-> (state_q == ST_FRAME));

  // R7
  close_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && (code_q == SYM_EOF || code_q == SYM_BREAK || code_q == SYM_ERR))
      |-> (state_q == ST_HUNT));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |-> (sym_code == 3'd0 && !sym_bit));

endmodule

// File: tb/vpw_symbol_classifier_bench.sv
`timescale 1ns/1ps
module vpw_symbol_classifier_bench;

  logic       clk;
  logic       rst_n;
  logic       rx_active;
  logic       tick_us;
  logic       sym_valid;
  logic [2:0] sym_code;
  logic       sym_bit;
  logic       break_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model state
  int m_prev, m_cnt, m_frame;
  int e_valid, e_code, e_bit, e_brk;
  int seen[$];

  vpw_symbol_classifier u_vpw_symbol_classifier (
    .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .tick_us(tick_us),
    .sym_valid(sym_valid), .sym_code(sym_code), .sym_bit(sym_bit),
    .break_flag(break_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic fail(string req, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic compare();
    checks++;
    if (sym_valid !== 1'(e_valid) || int'(sym_code) != e_code ||
        sym_bit !== 1'(e_bit) || break_flag !== 1'(e_brk)) begin
      fail(cur_req, "outputs{valid,code,bit,brk}",
           {28'd0, sym_valid, sym_code} * 4 + sym_bit * 2 + break_flag,
           (e_valid * 8 + e_code) * 4 + e_bit * 2 + e_brk);
    end
    if (sym_valid) seen.push_back(int'(sym_code) * 2 + sym_bit);
  endtask

  // behavioural reference: predicts outputs after the coming edge
  task automatic model_step(int rx, int tk);
    e_valid = 0; e_code = 0; e_bit = 0;
    if (rx != m_prev) begin
      e_brk = 0;
      if (m_frame == 0) begin
        if (m_prev == 1 && m_cnt >= 163 && m_cnt <= 239) begin
          e_valid = 1; e_code = 2; m_frame = 1;
        end
      end else if (m_cnt >= 34 && m_cnt <= 95) begin
        e_valid = 1; e_code = 0; e_bit = m_prev;
      end else if (m_cnt >= 96 && m_cnt <= 162) begin
        e_valid = 1; e_code = 1; e_bit = 1 - m_prev;
      end else if (m_prev == 1 && m_cnt >= 163 && m_cnt <= 239) begin
        e_valid = 1; e_code = 2;
      end else begin
        e_valid = 1; e_code = 5; m_frame = 0;
      end
      m_cnt = 0;
    end else if (tk == 1 && m_cnt < 255) begin
      m_cnt++;
      if (m_prev == 1 && m_cnt == 240) begin
        e_valid = 1; e_code = 3; e_brk = 1; m_frame = 0;
      end else if (m_prev == 0 && m_cnt == 239 && m_frame == 1) begin
        e_valid = 1; e_code = 4; m_frame = 0;
      end
    end
    m_prev = rx;
  endtask

  task automatic cyc(int rx, int tk);
    @(negedge clk);
    compare();
    rx_active = 1'(rx);
    tick_us   = 1'(tk);
    model_step(rx, tk);
  endtask

  // level change cycle (its tick is never counted), then n ticks
  task automatic pulse(int lvl, int n);
    cyc(lvl, 1);
    for (int i = 0; i < n; i++) begin
      cyc(lvl, 1);
      cyc(lvl, 0);
      cyc(lvl, 0);
    end
  endtask

  task automatic expect_sym(string req, int code, int b);
    checks++;
    if (seen.size() == 0) fail(req, "missing symbol code*2+bit", -1, code * 2 + b);
    else begin
      int got = seen.pop_front();
      if (got != code * 2 + b) fail(req, "symbol code*2+bit", got, code * 2 + b);
    end
  endtask

  task automatic expect_none(string req);
    checks++;
    if (seen.size() != 0) fail(req, "extra symbols", seen.size(), 0);
    seen.delete();
  endtask

  initial begin
    rst_n = 1'b0; rx_active = 1'b0; tick_us = 1'b0;
    m_prev = 0; m_cnt = 0; m_frame = 0;
    e_valid = 0; e_code = 0; e_bit = 0; e_brk = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (sym_valid !== 1'b0 || sym_code !== 3'd0 || sym_bit !== 1'b0 || break_flag !== 1'b0)
      fail("R1", "reset outputs", {28'd0, sym_valid, sym_code}, 0);
    rst_n = 1'b1;
    model_step(0, 0);
    repeat (4) cyc(0, 0);
    expect_none("R1");

    // R4 noise while hunting
    cur_req = "R4 R2 R11";
    pulse(1, 100); pulse(0, 50); pulse(1, 162); pulse(0, 300); pulse(1, 20); pulse(0, 10);
    expect_none("R4");

    // R3 R5 R10 R7 window edges
    cur_req = "R3 R5 R10 R7 R2 R11";
    pulse(1, 163); pulse(0, 34); pulse(1, 95); pulse(0, 96); pulse(1, 162);
    pulse(0, 60); pulse(1, 200); pulse(0, 245); pulse(1, 5); pulse(0, 5);
    expect_sym("R3", 2, 0);
    expect_sym("R5", 0, 0);
    expect_sym("R5", 0, 1);
    expect_sym("R5", 1, 1);
    expect_sym("R5", 1, 0);
    expect_sym("R5", 0, 0);
    expect_sym("R10", 2, 0);
    expect_sym("R7", 4, 0);
    expect_none("R7");

    // R8 errors close the frame
    cur_req = "R8 R3 R4";
    pulse(1, 239); pulse(0, 33); pulse(1, 50); pulse(0, 40);
    pulse(1, 170); pulse(0, 200); pulse(1, 60); pulse(0, 20);
    expect_sym("R3", 2, 0);
    expect_sym("R8", 5, 0);
    expect_sym("R3", 2, 0);
    expect_sym("R8", 5, 0);
    expect_none("R8");

    // R6 BREAK inside a frame, flag held, then hunt
    cur_req = "R6";
    pulse(1, 170); pulse(0, 50); pulse(1, 300);
    checks++;
    if (break_flag !== 1'b1) fail("R6", "break_flag during long active", break_flag, 1);
    pulse(0, 40);
    checks++;
    if (break_flag !== 1'b0) fail("R6", "break_flag after passive", break_flag, 0);
    pulse(1, 60); pulse(0, 30);
    expect_sym("R3", 2, 0);
    expect_sym("R5", 0, 0);
    expect_sym("R6", 3, 0);
    expect_none("R6");

    // R9 saturation: one BREAK, SOF after a very long gap
    cur_req = "R9 R6 R5";
    pulse(1, 600); pulse(0, 400); pulse(1, 180); pulse(0, 100); pulse(1, 20); pulse(0, 10);
    expect_sym("R9", 3, 0);
    expect_sym("R9", 2, 0);
    expect_sym("R5", 1, 1);
    expect_sym("R8", 5, 0);
    expect_none("R9");

    repeat (4) cyc(0, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule